// File: doc/BRIEF.md
# Gated Sample Integrator with Snapshot Registers

This block keeps a running signed sum of a stream of input samples and counts how many samples went into that sum. Two conditions gate the accumulation, an enable and a halt. Each condition comes from its own hardware pin or from its own software control bit, and the choice is made separately for each. A gate state machine tracks whether the integrator is accumulating. It has two states:

- `ST_HOLD`: samples are ignored.
- `ST_ACCUM`: every valid sample is added to the sum.

The machine moves `ST_HOLD -> ST_ACCUM` on the first clock edge at which the gate (enable and not halt) is true. It moves `ST_ACCUM -> ST_HOLD` on the first edge at which the gate is false. It stays in its state otherwise.

A zero command restarts the live sum and the internal sample count. The command comes from a rising edge on a pin or from a software strobe bit. The snapshot registers are separate from the live sum. The live-count register is refreshed only when the live sum is read. The final sum and final count are refreshed only on an output request. Sticky overflow flags record signed sum overflow and count wrap. They are raised on an update, which is an output request or a live-sum read, and only when the internal overflow state is set at that update.

Software reaches the block through a simple register port with single-cycle writes and reads. Read data is combinational on the address.

Top module: `gated_integrator`

## Requirements
- R1: A low `rst_n` clears the live sum, internal count, live count, final sum, final count, control bits, both overflow flags and the internal overflow state. All registers then read 0.
- R2: The gate state machine enters `ST_ACCUM` one clock edge after the gate is true and enters `ST_HOLD` one edge after it is false. A sample with `smp_valid` high is added, sign-extended from 16 to 32 bits, only while the machine is in `ST_ACCUM`. Each added sample raises the internal count by one.
- R3: Control register (address 0): bit0 selects the enable source (1 = bit1, 0 = `pin_enable`), and bit2 selects the halt source (1 = bit3, 0 = `pin_halt`). Any mix of the two sources is valid. Both pins are level sensitive.
- R4: A zero command clears the live sum, internal count and internal overflow state at the clock edge where it occurs. A zero command is either a rising edge on `pin_zero` or a write to address 0 with bit4 set. A sample presented at that edge is discarded. The command acts whatever the gate state.
- R5: The live count (address 3) ignores zero commands. It loads the internal count only at an edge where `reg_rd` is high with address 2, the live sum.
- R6: An output request loads the final sum (address 4) and final count (address 5) from the live sum and internal count. An output request is either a rising edge on `pin_req` or a write to address 0 with bit5 set. Zero commands leave these registers unchanged. When a zero command and a request share an edge, the registers take the values from before the zero.
- R7: A signed overflow of the sum addition sets the internal sum-overflow state. Status bit0 (address 1) is set at the next update that sees this state.
- R8: A count increment from all ones wraps to zero and sets the internal count-overflow state. Status bit1 is set at the next update that sees this state.
- R9: A zero command leaves both status flags unchanged. Because it clears the internal overflow state, a later update with no new overflow leaves the flags clear.
- R10: Writing 1 to a status bit clears that flag. If an update sets the same flag in the same cycle, the flag ends up set.
- R11: A pin held high issues only one zero command or request. The pin must fall and rise again to issue another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed input sample |
| pin_enable | input | 1 | Hardware enable level |
| pin_halt | input | 1 | Hardware halt level |
| pin_zero | input | 1 | Hardware zero command, rising edge |
| pin_req | input | 1 | Hardware output request, rising edge |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on address 2) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |

## Verification
Most internal faults in this block stay invisible until a later event brings them to the ports. A gate machine stuck in one state shows up one edge after a source change, as a live sum that moves when it should hold, or holds when it should move. A live count or snapshot register disturbed by a zero command can be seen as soon as that register is read back. A stale or missing internal overflow state shows only at the next update, as a flag that appears or fails to appear. The bench therefore reads the status register straight after each update, and again after each zero command.

// File: rtl/gi_pkg.sv
package gi_pkg;
    typedef enum logic {
        ST_HOLD  = 1'b0,
        ST_ACCUM = 1'b1
    } gate_st_t;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_LSUM = 3'd2;
    localparam logic [ADDR_W-1:0] A_LCNT = 3'd3;
    localparam logic [ADDR_W-1:0] A_FSUM = 3'd4;
    localparam logic [ADDR_W-1:0] A_FCNT = 3'd5;

    localparam int B_EN_SEL   = 0;
    localparam int B_SW_EN    = 1;
    localparam int B_HALT_SEL = 2;
    localparam int B_SW_HALT  = 3;
    localparam int B_ZERO     = 4;
    localparam int B_REQ      = 5;

    localparam int B_SOVF = 0;
    localparam int B_COVF = 1;
endpackage

// File: rtl/gi_rise.sv
module gi_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            assign rise_o[i] = lvl_i[i] & ~prev_q[i];
        end
    endgenerate
endmodule

// File: rtl/gi_gate_fsm.sv
module gi_gate_fsm
    import gi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_sel_i,
    input  logic sw_en_i,
    input  logic pin_en_i,
    input  logic halt_sel_i,
    input  logic sw_halt_i,
    input  logic pin_halt_i,
    output logic accum_on_o
);
    gate_st_t state_q, state_d;
    logic     en_src, halt_src, gate;

    assign en_src   = en_sel_i   ? sw_en_i   : pin_en_i;
    assign halt_src = halt_sel_i ? sw_halt_i : pin_halt_i;
    assign gate     = en_src & ~halt_src;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (gate)  state_d = ST_ACCUM;
            ST_ACCUM: if (!gate) state_d = ST_HOLD;
            default:             state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        accum_on_o = (state_q == ST_ACCUM);
    end

    // R2: the accumulation status follows the gate one edge later
    assert_gate_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gate |=> accum_on_o);
    assert_gate_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> !accum_on_o);
endmodule

// File: rtl/gi_accum.sv
module gi_accum #(
    parameter int IN_W  = 16,
    parameter int SUM_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [IN_W-1:0]  data_i,
    input  logic             zero_i,
    output logic [SUM_W-1:0] sum_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sovf_o,
    output logic             covf_o
);
    localparam int EXT_W = SUM_W - IN_W;

    logic [SUM_W-1:0] sum_q, ext, add;
    logic [CNT_W-1:0] cnt_q;
    logic             sovf_q, covf_q, add_ovf, cnt_wrap;

    assign ext      = {{EXT_W{data_i[IN_W-1]}}, data_i};
    assign add      = sum_q + ext;
    assign add_ovf  = (sum_q[SUM_W-1] == ext[SUM_W-1]) && (add[SUM_W-1] != sum_q[SUM_W-1]);
    assign cnt_wrap = &cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || zero_i) begin
            sum_q  <= '0;
            cnt_q  <= '0;
            sovf_q <= 1'b0;
            covf_q <= 1'b0;
        end else if (take_i) begin
            sum_q  <= add;
            cnt_q  <= cnt_q + 1'b1;
            sovf_q <= sovf_q | add_ovf;
            covf_q <= covf_q | cnt_wrap;
        end
    end

    assign sum_o  = sum_q;
    assign cnt_o  = cnt_q;
    assign sovf_o = sovf_q;
    assign covf_o = covf_q;

    assert_zero_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_i |=> (sum_q == '0) && (cnt_q == '0) && !sovf_q && !covf_q);
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_i && !take_i) |=> $stable(sum_q) && $stable(cnt_q));
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_i && take_i) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/gated_integrator.sv
module gated_integrator
    import gi_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int SUM_W = 32,
    parameter int CNT_W = 16,
    parameter int BUS_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [IN_W-1:0]   smp_data,
    input  logic              pin_enable,
    input  logic              pin_halt,
    input  logic              pin_zero,
    input  logic              pin_req,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata
);
    logic             en_sel_q, sw_en_q, halt_sel_q, sw_halt_q;
    logic             accum_on;
    logic [1:0]       rise;
    logic             wr_ctrl, wr_stat, zero_evt, req_evt, live_rd, upd;
    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] cnt;
    logic             sovf_int, covf_int;
    logic [SUM_W-1:0] fsum_q;
    logic [CNT_W-1:0] fcnt_q, lcnt_q;
    logic             sflag_q, cflag_q;
    logic             clr_s, clr_c;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[BUS_W-1:B_REQ+1];

    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign wr_stat  = reg_wr && (reg_addr == A_STAT);
    assign zero_evt = (wr_ctrl && reg_wdata[B_ZERO]) || rise[0];
    assign req_evt  = (wr_ctrl && reg_wdata[B_REQ])  || rise[1];
    assign live_rd  = reg_rd && (reg_addr == A_LSUM);
    assign upd      = req_evt || live_rd;
    assign clr_s    = wr_stat && reg_wdata[B_SOVF];
    assign clr_c    = wr_stat && reg_wdata[B_COVF];

    gi_rise #(.N(2)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i ({pin_req, pin_zero}),
        .rise_o(rise)
    );

    gi_gate_fsm u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_sel_i  (en_sel_q),
        .sw_en_i   (sw_en_q),
        .pin_en_i  (pin_enable),
        .halt_sel_i(halt_sel_q),
        .sw_halt_i (sw_halt_q),
        .pin_halt_i(pin_halt),
        .accum_on_o(accum_on)
    );

    gi_accum #(.IN_W(IN_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .take_i(smp_valid && accum_on),
        .data_i(smp_data),
        .zero_i(zero_evt),
        .sum_o (sum),
        .cnt_o (cnt),
        .sovf_o(sovf_int),
        .covf_o(covf_int)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_sel_q   <= 1'b0;
            sw_en_q    <= 1'b0;
            halt_sel_q <= 1'b0;
            sw_halt_q  <= 1'b0;
        end else if (wr_ctrl) begin
            en_sel_q   <= reg_wdata[B_EN_SEL];
            sw_en_q    <= reg_wdata[B_SW_EN];
            halt_sel_q <= reg_wdata[B_HALT_SEL];
            sw_halt_q  <= reg_wdata[B_SW_HALT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsum_q  <= '0;
            fcnt_q  <= '0;
            lcnt_q  <= '0;
            sflag_q <= 1'b0;
            cflag_q <= 1'b0;
        end else begin
            if (req_evt) begin
                fsum_q <= sum;
                fcnt_q <= cnt;
            end
            if (live_rd) lcnt_q <= cnt;
            sflag_q <= (sflag_q & ~clr_s) | (upd & sovf_int);
            cflag_q <= (cflag_q & ~clr_c) | (upd & covf_int);
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata = BUS_W'({sw_halt_q, halt_sel_q, sw_en_q, en_sel_q});
            A_STAT: reg_rdata = BUS_W'({cflag_q, sflag_q});
            A_LSUM: reg_rdata = BUS_W'(sum);
            A_LCNT: reg_rdata = BUS_W'(lcnt_q);
            A_FSUM: reg_rdata = BUS_W'(fsum_q);
            A_FCNT: reg_rdata = BUS_W'(fcnt_q);
            default: reg_rdata = '0;
        endcase
    end

    assert_final_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_evt |=> $stable(fsum_q) && $stable(fcnt_q));
    assert_livecnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !live_rd |=> $stable(lcnt_q));
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sflag_q && !clr_s) |=> sflag_q);
    assert_sflag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && sovf_int) |=> sflag_q);
    assert_cflag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && covf_int) |=> cflag_q);
    assert_no_spurious_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sflag_q && !(upd && sovf_int)) |=> !sflag_q);
endmodule

// File: tb/gated_integrator_tb.sv
`timescale 1ns/1ps
module gated_integrator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        pin_enable = 1'b0, pin_halt = 1'b0, pin_zero = 1'b0, pin_req = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int  n_total = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    gated_integrator dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .pin_enable(pin_enable), .pin_halt(pin_halt), .pin_zero(pin_zero), .pin_req(pin_req),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    localparam int NV = 8;
    localparam logic [NV-1:0] TV_VLD = 8'b1111_1101;
    localparam logic signed [15:0] TV_DATA [NV] =
        '{16'sd100, -16'sd50, -16'sd50, 16'sd32767, -16'sd32768, 16'sd7, 16'sd0, -16'sd1};
    localparam int TV_SUM [NV] = '{100, 100, 50, 32817, 49, 56, 56, 55};

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic push(input logic [15:0] d);
        smp_valid = 1'b1; smp_data = d;
        tick();
        smp_valid = 1'b0;
    endtask

    task automatic live_read();
        reg_rd = 1'b1; reg_addr = 3'd2;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        n_total++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, reg_rdata, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1: everything reads zero in reset
        for (int a = 0; a < 6; a++) expect_reg(3'(a), 32'd0, "R1");
        rst_n = 1'b1;
        tick();

        // R3: software enable, software halt off
        bus_wr(3'd0, 32'h7);
        tick();
        // R2: vector table
        for (int i = 0; i < NV; i++) begin
            smp_valid = TV_VLD[i]; smp_data = TV_DATA[i];
            tick();
            smp_valid = 1'b0;
            expect_reg(3'd2, 32'(TV_SUM[i]), "R2");
        end
        live_read();
        expect_reg(3'd3, 32'd7, "R5");

        // R3: software halt
        bus_wr(3'd0, 32'hF);
        tick();
        push(16'd10);
        expect_reg(3'd2, 32'd55, "R3");
        // R3: hardware halt pin with software enable
        pin_halt = 1'b1;
        bus_wr(3'd0, 32'h3);
        tick();
        push(16'd10);
        expect_reg(3'd2, 32'd55, "R3");
        pin_halt = 1'b0;
        tick();
        push(16'd5);
        expect_reg(3'd2, 32'd60, "R3");
        // R3: hardware enable pin
        bus_wr(3'd0, 32'h0);
        tick();
        push(16'd5);
        expect_reg(3'd2, 32'd60, "R3");
        pin_enable = 1'b1;
        tick();
        push(16'd5);
        expect_reg(3'd2, 32'd65, "R3");

        // R6: software request
        bus_wr(3'd0, 32'h20);
        expect_reg(3'd4, 32'd65, "R6");
        expect_reg(3'd5, 32'd9, "R6");
        expect_reg(3'd3, 32'd7, "R5");

        // R4: pin zero drops the coincident sample
        pin_zero = 1'b1;
        smp_valid = 1'b1; smp_data = 16'd100;
        tick();
        smp_valid = 1'b0;
        expect_reg(3'd2, 32'd0, "R4");
        // R11: held pin does not zero again
        push(16'd3);
        expect_reg(3'd2, 32'd3, "R11");
        pin_zero = 1'b0;
        expect_reg(3'd4, 32'd65, "R6");
        expect_reg(3'd3, 32'd7, "R5");
        live_read();
        expect_reg(3'd3, 32'd1, "R5");

        // R6: zero and request on the same edge
        push(16'd4);
        pin_req = 1'b1; pin_zero = 1'b1;
        tick();
        pin_req = 1'b0; pin_zero = 1'b0;
        expect_reg(3'd4, 32'd7, "R6");
        expect_reg(3'd5, 32'd2, "R6");
        expect_reg(3'd2, 32'd0, "R4");

        // R4: software zero while gated off
        push(16'd11);
        pin_enable = 1'b0;
        tick();
        push(16'd9);
        expect_reg(3'd2, 32'd11, "R2");
        bus_wr(3'd0, 32'h10);
        expect_reg(3'd2, 32'd0, "R4");
        live_read();
        expect_reg(3'd3, 32'd0, "R4");

        // R7/R8: long run overflows sum and count
        pin_enable = 1'b1;
        tick();
        smp_valid = 1'b1; smp_data = 16'h7FFF;
        repeat (65540) tick();
        smp_valid = 1'b0;
        expect_reg(3'd2, 32'h8000FFFC, "R7");
        expect_reg(3'd1, 32'd0, "R7");
        // R10: request and clear in the same cycle; set wins
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h3; pin_req = 1'b1;
        tick();
        reg_wr = 1'b0; reg_wdata = '0; pin_req = 1'b0;
        expect_reg(3'd1, 32'd3, "R10");
        expect_reg(3'd4, 32'h8000FFFC, "R7");
        expect_reg(3'd5, 32'd4, "R8");

        // R9: zero keeps the flags but clears the internal state
        bus_wr(3'd0, 32'h10);
        expect_reg(3'd1, 32'd3, "R9");
        bus_wr(3'd1, 32'h3);
        expect_reg(3'd1, 32'd0, "R10");
        live_read();
        expect_reg(3'd1, 32'd0, "R9");

        // R1: reset mid-run clears the snapshots
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        expect_reg(3'd4, 32'd0, "R1");
        expect_reg(3'd5, 32'd0, "R1");
        expect_reg(3'd0, 32'd0, "R1");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule